// File: doc/BRIEF.md
# Dual Byte-Queue Control Unit for an Infrared Serial Port

This unit holds a transmit byte queue and a receive byte queue, each 64 entries deep by default. A single 8-bit memory-mapped control register manages both queues. A register write can turn both queues on or off, flush either queue on its own, switch the queues between full depth and a single-byte holding mode, and pick the receive occupancy at which an interrupt request is raised. The serial side of the port pushes received bytes and pops bytes to send through plain push and pop ports. Each queue reports full, empty and its occupancy.

Each flush takes one clock cycle. When a flush finishes, a sticky completion flag for that queue is set in the register. A read of the register clears the flag. Any change of the enable bit flushes both queues. The receive request uses four uneven thresholds, so software can choose how many bytes arrive before it is interrupted.

Top module: `serial_fifo_ctl`

## Requirements
- R1: After reset the register reads 0x00, both queues are empty with occupancy 0, and rx_trig is low.
- R2: A write with bit 0 set loads the level select from bits [7:6] and the depth select from bit 5, and sets the enable. A write with bit 0 clear only clears the enable; bits [7:5] keep their old value.
- R3: With the enable already 1, a write of bit 0 = 1 and bit 2 = 1 empties the transmit queue: its occupancy reads 0 one cycle after the write cycle. The receive queue is untouched.
- R4: With the enable already 1, a write of bit 0 = 1 and bit 1 = 1 empties the receive queue in the same way.
- R5: The transmit completion flag (bit 4) and the receive completion flag (bit 3) become 1 in the cycle after the matching flush and stay 1 until a register read clears them. If a read falls in the flush cycle itself, the flag still becomes 1.
- R6: A write whose bit 0 differs from the current enable flushes both queues.
- R7: Bits 2 and 1 always read as 0.
- R8: rx_trig is high exactly when the enable is 1 and the receive occupancy is at least the selected level. The level selects on bits [7:6] are 00 = 1, 01 = 16, 10 = 32 and 11 = 56.
- R9: With depth select 1, each queue holds 64 bytes and returns them in push order. Full is raised at 64, and a push while full is ignored.
- R10: A pop while empty is ignored. Empty stays high and the occupancy stays 0.
- R11: With depth select 0, each queue holds at most one byte. A second push is ignored and full is raised at occupancy 1.
- R12: While the enable is 0, pushes and pops have no effect on either queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears completion flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_din | input | 8 | Transmit push data |
| tx_pop | input | 1 | Pop the transmit queue head |
| tx_dout | output | 8 | Transmit queue head |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_count | output | 7 | Transmit occupancy |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_din | input | 8 | Receive push data |
| rx_pop | input | 1 | Pop the receive queue head |
| rx_dout | output | 8 | Receive queue head |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_count | output | 7 | Receive occupancy |
| rx_trig | output | 1 | Receive level interrupt request |

## Verification
The bench builds the unit with its default parameters: 8-bit data, a depth of 64, and thresholds of 1, 16, 32 and 56. With these values every threshold can be reached in a short run. The bench fills the receive queue past each threshold and right up to full, checking the request at count values just below and at each level. Because the depth is a power of two, the pointer wrap and the full-depth order are exercised. Switching the depth select to 0 in the same build covers the single-byte mode.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam int REG_W      = 8;
   localparam int B_EN       = 0;
   localparam int B_RXCLR    = 1;
   localparam int B_TXCLR    = 2;
   localparam int B_RXDONE   = 3;
   localparam int B_TXDONE   = 4;
   localparam int B_DEEP     = 5;
   localparam int B_LVL_LO   = 6;
   localparam int N_CHAN     = 2;
   localparam int CH_TX      = 0;
   localparam int CH_RX      = 1;

   typedef struct packed {
      logic [1:0] lvl_sel;
      logic       deep;
      logic       en;
   } sfc_cfg_t;
endpackage

// File: rtl/sfc_ctrl_reg.sv
module sfc_ctrl_reg
   import sfc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output sfc_cfg_t         cfg,
   output logic [N_CHAN-1:0] flush
);
   logic             en_q, deep_q;
   logic [1:0]       lvl_q;
   logic [N_CHAN-1:0] flush_q;
   logic [N_CHAN-1:0] done_q;
   logic [N_CHAN-1:0] flush_req;

   // flush request decode for one write
   always_comb begin
      flush_req = '0;
      if (wr) begin
         if (wdata[B_EN] != en_q) begin
            flush_req = '1;
         end else if (wdata[B_EN]) begin
            flush_req[CH_TX] = wdata[B_TXCLR];
            flush_req[CH_RX] = wdata[B_RXCLR];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         deep_q  <= 1'b0;
         lvl_q   <= 2'b00;
         flush_q <= '0;
      end else begin
         flush_q <= flush_req;
         if (wr) begin
            en_q <= wdata[B_EN];
            if (wdata[B_EN]) begin
               lvl_q  <= wdata[B_LVL_LO +: 2];
               deep_q <= wdata[B_DEEP];
            end
         end
      end
   end

   // sticky completion flags, set has priority over read clear
   genvar c;
   generate
      for (c = 0; c < N_CHAN; c++) begin : g_done
         always_ff @(posedge clk) begin
            if (!rst_n)          done_q[c] <= 1'b0;
            else if (flush_q[c]) done_q[c] <= 1'b1;
            else if (rd)         done_q[c] <= 1'b0;
         end
      end
   endgenerate

   always_comb begin
      rdata                 = '0;
      rdata[B_EN]           = en_q;
      rdata[B_RXDONE]       = done_q[CH_RX];
      rdata[B_TXDONE]       = done_q[CH_TX];
      rdata[B_DEEP]         = deep_q;
      rdata[B_LVL_LO +: 2]  = lvl_q;
   end

   assign cfg.en      = en_q;
   assign cfg.deep    = deep_q;
   assign cfg.lvl_sel = lvl_q;
   assign flush       = flush_q;
endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          deep,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sfc_fifo: DEPTH must be a power of two of at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("sfc_fifo: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic [CW-1:0] cap;
   logic          do_push, do_pop;

   assign cap     = deep ? CW'(DEPTH) : CW'(1);
   assign full    = (cnt >= cap);
   assign empty   = (cnt == '0);
   assign do_push = en && push && !full  && !flush;
   assign do_pop  = en && pop  && !empty && !flush;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign dout  = mem[rp];
   assign count = cnt;
endmodule

// File: rtl/sfc_trigger.sv
module sfc_trigger #(
   parameter int DEPTH = 64,
   parameter int LVL0  = 1,
   parameter int LVL1  = 16,
   parameter int LVL2  = 32,
   parameter int LVL3  = 56,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          en,
   input  logic [1:0]    sel,
   input  logic [CW-1:0] count,
   output logic          trig
);
   localparam int LV [4] = '{LVL0, LVL1, LVL2, LVL3};

   genvar i;
   generate
      for (i = 0; i < 4; i++) begin : g_chk
         if (LV[i] < 1 || LV[i] > DEPTH) begin : g_bad
            $error("sfc_trigger: level out of range 1..DEPTH");
         end
      end
   endgenerate

   logic [CW-1:0] lvl;
   always_comb begin
      case (sel)
         2'd0:    lvl = CW'(LVL0);
         2'd1:    lvl = CW'(LVL1);
         2'd2:    lvl = CW'(LVL2);
         default: lvl = CW'(LVL3);
      endcase
   end

   assign trig = en && (count >= lvl);
endmodule

// File: rtl/serial_fifo_ctl.sv
module serial_fifo_ctl
   import sfc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   parameter int LVL0  = 1,
   parameter int LVL1  = 16,
   parameter int LVL2  = 32,
   parameter int LVL3  = 56,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             tx_push,
   input  logic [DW-1:0]    tx_din,
   input  logic             tx_pop,
   output logic [DW-1:0]    tx_dout,
   output logic             tx_full,
   output logic             tx_empty,
   output logic [CW-1:0]    tx_count,
   input  logic             rx_push,
   input  logic [DW-1:0]    rx_din,
   input  logic             rx_pop,
   output logic [DW-1:0]    rx_dout,
   output logic             rx_full,
   output logic             rx_empty,
   output logic [CW-1:0]    rx_count,
   output logic             rx_trig
);
   sfc_cfg_t          cfg;
   logic [N_CHAN-1:0] flush;
   logic [N_CHAN-1:0] push_a, pop_a, full_a, empty_a;
   logic [DW-1:0]     din_a  [N_CHAN];
   logic [DW-1:0]     dout_a [N_CHAN];
   logic [CW-1:0]     cnt_a  [N_CHAN];

   sfc_ctrl_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .rd    (reg_rd),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .cfg   (cfg),
      .flush (flush)
   );

   assign push_a[CH_TX] = tx_push;
   assign push_a[CH_RX] = rx_push;
   assign pop_a[CH_TX]  = tx_pop;
   assign pop_a[CH_RX]  = rx_pop;
   assign din_a[CH_TX]  = tx_din;
   assign din_a[CH_RX]  = rx_din;

   genvar c;
   generate
      for (c = 0; c < N_CHAN; c++) begin : g_q
         sfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cfg.en),
            .deep  (cfg.deep),
            .flush (flush[c]),
            .push  (push_a[c]),
            .din   (din_a[c]),
            .pop   (pop_a[c]),
            .dout  (dout_a[c]),
            .full  (full_a[c]),
            .empty (empty_a[c]),
            .count (cnt_a[c])
         );
      end
   endgenerate

   assign tx_dout  = dout_a[CH_TX];
   assign tx_full  = full_a[CH_TX];
   assign tx_empty = empty_a[CH_TX];
   assign tx_count = cnt_a[CH_TX];
   assign rx_dout  = dout_a[CH_RX];
   assign rx_full  = full_a[CH_RX];
   assign rx_empty = empty_a[CH_RX];
   assign rx_count = cnt_a[CH_RX];

   sfc_trigger #(
      .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
   ) u_trig (
      .en    (cfg.en),
      .sel   (cfg.lvl_sel),
      .count (cnt_a[CH_RX]),
      .trig  (rx_trig)
   );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
   parameter int DEPTH = 64,
   parameter int CW    = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [7:0]    reg_wdata,
   input logic [7:0]    reg_rdata,
   input logic          tx_push,
   input logic          tx_pop,
   input logic          tx_full,
   input logic [CW-1:0] tx_count,
   input logic          rx_push,
   input logic          rx_pop,
   input logic          rx_empty,
   input logic [CW-1:0] rx_count
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && !reg_wdata[0] |=> $stable(reg_rdata[7:5]));

   p_tx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[0] && reg_rdata[0] && reg_wdata[2] |=> ##1 (tx_count == '0));

   p_rx_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[0] && reg_rdata[0] && reg_wdata[1] |=> ##1 (rx_count == '0));

   p_tx_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_wdata[0] && reg_rdata[0] && reg_wdata[2] |=> ##1 reg_rdata[4]);

   p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && !$past(reg_wr) |=> !reg_rdata[4] && !reg_rdata[3]);

   p_en_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && (reg_wdata[0] != reg_rdata[0]) |=> ##1 (tx_count == '0 && rx_count == '0));

   p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2:1] == 2'b00);

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= DEPTH_C && rx_count <= DEPTH_C);

   p_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full && tx_push && !tx_pop |=> tx_count <= $past(tx_count));

   p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty && rx_pop && !rx_push |=> rx_empty);

   p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[5] && tx_count != '0 && tx_push |=> tx_count <= $past(tx_count));

   p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[0] |=> tx_count <= $past(tx_count) && rx_count <= $past(rx_count));
endmodule

bind serial_fifo_ctl sfc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .tx_push   (tx_push),
   .tx_pop    (tx_pop),
   .tx_full   (tx_full),
   .tx_count  (tx_count),
   .rx_push   (rx_push),
   .rx_pop    (rx_pop),
   .rx_empty  (rx_empty),
   .rx_count  (rx_count)
);

// File: tb/sim_serial_fifo_ctl.sv
module sim_serial_fifo_ctl;
   localparam int CLK_P = 10;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
   logic       tx_full, tx_empty, rx_full, rx_empty, rx_trig;
   logic [6:0] tx_count, rx_count;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   always #(CLK_P/2) clk = ~clk;

   serial_fifo_ctl #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
      .tx_full(tx_full), .tx_empty(tx_empty), .tx_count(tx_count),
      .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
      .rx_full(rx_full), .rx_empty(rx_empty), .rx_count(rx_count),
      .rx_trig(rx_trig)
   );

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd();
      reg_rd = 1'b1;
      tick();
      reg_rd = 1'b0;
   endtask

   // driver side of the scoreboard
   task automatic push_tx(input logic [7:0] b, input bit acc);
      tx_push = 1'b1; tx_din = b;
      if (acc) txq.push_back(b);
      tick();
      tx_push = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] b, input bit acc);
      rx_push = 1'b1; rx_din = b;
      if (acc) rxq.push_back(b);
      tick();
      rx_push = 1'b0;
   endtask

   task automatic pop_tx();
      tx_pop = 1'b1; tick(); tx_pop = 1'b0;
   endtask

   task automatic pop_rx();
      rx_pop = 1'b1; tick(); rx_pop = 1'b0;
   endtask

   // monitor: compares the queue head against the scoreboard when a pop is applied
   always begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && tx_pop && txq.size() != 0) check("R9 tx data order", int'(tx_dout), int'(txq.pop_front()));
      if (rst_n && rx_pop && rxq.size() != 0) check("R9 rx data order", int'(rx_dout), int'(rxq.pop_front()));
   end

   initial begin
      repeat (200000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int v;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1 rdata", reg_rdata, 8'h00);
      check("R1 tx_empty", tx_empty, 1);
      check("R1 rx_count", rx_count, 0);
      check("R1 rx_trig", rx_trig, 0);

      // enable, deep, level 1: enable change flushes both
      wr(8'h21); tick();
      check("R6 both flags after enable", reg_rdata, 8'h39);
      rd();
      check("R5 flags cleared by read", reg_rdata, 8'h21);

      // tx order
      push_tx(8'hA5, 1); push_tx(8'h3C, 1); push_tx(8'h7E, 1);
      check("R9 tx_count 3", tx_count, 3);
      repeat (3) pop_tx();
      check("R9 tx_empty after pops", tx_empty, 1);

      // receive levels
      v = 0;
      wr(8'h61);
      repeat (15) begin push_rx(8'(v), 1); v++; end
      check("R8 level 16 at 15", rx_trig, 0);
      push_rx(8'(v), 1); v++;
      check("R8 level 16 at 16", rx_trig, 1);
      wr(8'hA1);
      check("R8 level 32 at 16", rx_trig, 0);
      repeat (15) begin push_rx(8'(v), 1); v++; end
      check("R8 level 32 at 31", rx_trig, 0);
      push_rx(8'(v), 1); v++;
      check("R8 level 32 at 32", rx_trig, 1);
      wr(8'hE1);
      check("R8 level 56 at 32", rx_trig, 0);
      repeat (23) begin push_rx(8'(v), 1); v++; end
      check("R8 level 56 at 55", rx_trig, 0);
      push_rx(8'(v), 1); v++;
      check("R8 level 56 at 56", rx_trig, 1);
      repeat (8) begin push_rx(8'(v), 1); v++; end
      check("R9 rx_full at 64", rx_full, 1);
      check("R9 rx_count 64", rx_count, 64);
      push_rx(8'hEE, 0);
      check("R9 push when full ignored", rx_count, 64);
      wr(8'h21);
      check("R8 level 1 select", rx_trig, 1);
      repeat (64) pop_rx();
      check("R10 rx_empty after drain", rx_empty, 1);
      check("R8 no request at 0", rx_trig, 0);
      pop_rx();
      check("R10 pop when empty count", rx_count, 0);
      check("R10 pop when empty flag", rx_empty, 1);

      // receive flush
      push_rx(8'h10, 1); push_rx(8'h20, 1);
      wr(8'h23); tick();
      check("R4 rx flushed", rx_count, 0);
      check("R5 rx flag only", reg_rdata, 8'h29);
      rxq.delete();
      rd();

      // transmit flush leaves rx alone
      repeat (5) push_tx(8'h5A, 1);
      push_rx(8'h01, 1); push_rx(8'h02, 1);
      wr(8'hE5); tick();
      txq.delete();
      check("R3 tx flushed", tx_count, 0);
      check("R3 rx untouched", rx_count, 2);
      check("R5 tx flag set", reg_rdata[4], 1);
      check("R7 command bits read 0", reg_rdata[2:1], 0);
      rd();
      wr(8'hE5);
      reg_rd = 1'b1; tick(); reg_rd = 1'b0;
      check("R5 set wins over read", reg_rdata[4], 1);
      rd();
      check("R5 cleared by later read", reg_rdata[4], 0);
      wr(8'hE3); tick();
      rxq.delete();
      check("R4 rx flushed second", rx_count, 0);
      rd();

      // disable: ignores upper bits, flushes
      push_tx(8'h44, 1);
      wr(8'h00); tick();
      txq.delete();
      check("R2 upper bits kept on disable", reg_rdata[7:5], 3'b111);
      check("R2 enable cleared", reg_rdata[0], 0);
      check("R6 tx flushed on disable", tx_count, 0);
      push_tx(8'h55, 0); push_rx(8'h66, 0);
      check("R12 tx push ignored", tx_count, 0);
      check("R12 rx push ignored", rx_count, 0);
      wr(8'hC0);
      check("R2 disabled write ignored", reg_rdata[7:5], 3'b111);
      rd();

      // single-byte mode
      wr(8'h01); tick();
      check("R2 depth select loaded", reg_rdata[5], 0);
      push_tx(8'h11, 1);
      check("R11 count 1", tx_count, 1);
      check("R11 full at 1", tx_full, 1);
      push_tx(8'h22, 0);
      check("R11 second push ignored", tx_count, 1);
      pop_tx();
      check("R11 empty after pop", tx_empty, 1);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule